// File: doc/BRIEF.md
# DMA Interrupt Status Aggregator

This block keeps the interrupt status of a packet DMA engine. The transmit and receive engines report events as single-cycle pulses. Each pulse sets a sticky flag, and the flag stays set until software writes a 1 to its bit. The block derives two sticky summaries from these flags: a normal one and an abnormal one. Each flag takes part in its summary only while its bit in the enable mask is set. The interrupt line is the registered OR of the two summaries.

The same status word also carries several read-only fields. The current transmit and receive process states pass straight through from outside. A 3-bit access-type code describes the most recent fatal bus error, and it is shown only while the fatal-bus-error flag is set. Software clears bits by writing the status word with 1s in the positions to clear.

Top module: `dma_irq_status`

Status word layout at default parameters:
- Bits 0..3 are the normal flags: transmit done, transmit buffer unavailable, receive done, early receive.
- Bits 4..12 are the abnormal flags: transmit stopped, transmit jabber, receive overflow, transmit underflow, receive buffer unavailable, receive stopped, receive watchdog, early transmit, fatal bus error (bit 12).
- Bit 13 is the normal summary and bit 14 is the abnormal summary.
- Bits 17:15 hold the error code, bits 20:18 the transmit state and bits 23:21 the receive state.
- Bits 31:24 read as zero.

## Requirements
- R1: An event pulse on bit i of `evt_i` sets status flag i at the next clock edge. The flag stays set while no write-1 targets it, and a write with a 0 in that position has no effect.
- R2: A write with `wr_en_i` high and a 1 at flag position i clears flag i at the next clock edge.
- R3: When an event pulse and a write-1 hit the same flag in the same cycle, the flag is set after the edge.
- R4: The normal summary (bit 13, `sum_norm_o`) becomes 1 one edge after any of flags 0..3 is set with its enable bit in `irq_en_i` set. A flag whose enable bit is clear never sets it.
- R5: The abnormal summary (bit 14, `sum_abn_o`) becomes 1 one edge after any of flags 4..12 is set with its enable bit set. Disabled flags never set it.
- R6: A summary is sticky. It stays 1 after its causing flag is cleared or disabled, and it clears only on a write-1 to its bit. A write-1 has no effect while an enabled flag of its group is still set.
- R7: An event on receive done (bit 2) clears the early-receive flag (bit 3) at the same edge, even when an early-receive event arrives in that same cycle.
- R8: An event on the fatal-bus-error flag (bit 12) latches `err_code_i` into bits 17:15. The field reads 0 while flag 12 is clear. The code never changes the summaries or `irq_o` on its own. Codes are: 0 receive data write, 3 transmit data read, 4 receive descriptor write, 5 transmit descriptor write, 6 receive descriptor read, 7 transmit descriptor read, 1 and 2 reserved.
- R9: Bits 20:18 equal `tx_state_i` and bits 23:21 equal `rx_state_i` in the same cycle. Bits 31:24 read 0. Writes to all of these bits, and to the error field, are ignored.
- R10: `irq_o` equals the OR of the two summaries as they stood one clock earlier.
- R11: After reset, the whole status word, both summaries and `irq_o` are 0 (with zero process-state inputs).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 13 | Single-cycle event pulses, one per flag |
| err_code_i | input | 3 | Access-type code, sampled with a fatal-bus-error pulse |
| tx_state_i | input | 3 | Current transmit process state |
| rx_state_i | input | 3 | Current receive process state |
| irq_en_i | input | 13 | Per-flag enable into the summaries |
| wr_en_i | input | 1 | Status write strobe |
| wr_data_i | input | 32 | Write data; 1 bits clear flags and summaries |
| status_o | output | 32 | Status word |
| sum_norm_o | output | 1 | Normal summary |
| sum_abn_o | output | 1 | Abnormal summary |
| irq_o | output | 1 | Registered combined interrupt |

## Verification
The assertions check on every cycle the rules that hold regardless of history:
- an event sets its flag;
- an uncleared flag persists;
- receive done clears early receive;
- an enabled flag raises its summary;
- the interrupt line follows the summaries by one cycle;
- the error field is hidden while the fatal flag is clear;
- the read-only fields track their inputs.

Some behaviour only the bench scenarios, compared cycle by cycle against a reference model, can show:
- a summary keeping its value after its cause is gone;
- a write-1 to a summary being refused while an enabled flag remains;
- the exact latched error code;
- writes having no effect on the read-only fields.

// File: rtl/dma_irq_pkg.sv
// Package: shared constants for the DMA interrupt status aggregator.
// Assumes: normal flags occupy the low positions, abnormal flags follow,
// and the fatal-bus-error flag is the highest flag.
package dma_irq_pkg;

    localparam int NORM_N = 4;
    localparam int ABN_N  = 9;
    localparam int FLAG_N = NORM_N + ABN_N;

    // Normal group
    localparam int FL_TX_DONE   = 0;
    localparam int FL_TX_NOBUF  = 1;
    localparam int FL_RX_DONE   = 2;
    localparam int FL_RX_EARLY  = 3;
    // Abnormal group
    localparam int FL_TX_STOP   = 4;
    localparam int FL_TX_JABBER = 5;
    localparam int FL_RX_OVF    = 6;
    localparam int FL_TX_UNF    = 7;
    localparam int FL_RX_NOBUF  = 8;
    localparam int FL_RX_STOP   = 9;
    localparam int FL_RX_WDOG   = 10;
    localparam int FL_TX_EARLY  = 11;
    localparam int FL_BUS_FATAL = 12;

    // Access type recorded on a fatal bus error
    typedef enum logic [2:0] {
        BERR_RX_DATA_WR = 3'd0,
        BERR_RSVD_1     = 3'd1,
        BERR_RSVD_2     = 3'd2,
        BERR_TX_DATA_RD = 3'd3,
        BERR_RX_DESC_WR = 3'd4,
        BERR_TX_DESC_WR = 3'd5,
        BERR_RX_DESC_RD = 3'd6,
        BERR_TX_DESC_RD = 3'd7
    } bus_err_e;

endpackage

// File: rtl/irq_flag_bank.sv
// Module: irq_flag_bank
// A bank of N sticky event flags. An event sets its flag, and a clear
// request (write-1) resets it. An event beats a clear in the same cycle.
// A per-bit auto-clear input beats both.
// Assumes: events are single-cycle pulses; clr_i is already qualified by
// the write strobe.
module irq_flag_bank #(
    parameter int N = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] autoclr_i,
    output logic [N-1:0] flags_o
);

    logic [N-1:0] flag_q;

    for (genvar b = 0; b < N; b++) begin : g_flag
        // Purpose: one sticky flag with priority auto-clear > event > clear
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q[b] <= 1'b0;
            end else if (autoclr_i[b]) begin
                flag_q[b] <= 1'b0;
            end else if (ev_i[b]) begin
                flag_q[b] <= 1'b1;
            end else if (clr_i[b]) begin
                flag_q[b] <= 1'b0;
            end
        end
    end

    assign flags_o = flag_q;

endmodule

// File: rtl/irq_summary.sv
// Module: irq_summary
// A sticky summary bit over a group of N flags. It sets while any enabled
// flag is set, and it clears on a write-1 only when no enabled flag remains.
// Assumes: flags_i are registered flags, so the summary lags them by one edge.
module irq_summary #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] flags_i,
    input  logic [N-1:0] en_i,
    input  logic         clr_i,
    output logic         sum_o
);

    logic hit;
    logic sum_q;

    // Purpose: detect any flag of the group that is both set and enabled
    always_comb begin
        hit = |(flags_i & en_i);
    end

    // Purpose: sticky summary register, set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= 1'b0;
        end else if (hit) begin
            sum_q <= 1'b1;
        end else if (clr_i) begin
            sum_q <= 1'b0;
        end
    end

    assign sum_o = sum_q;

endmodule

// File: rtl/irq_err_latch.sv
// Module: irq_err_latch
// Captures the bus-error access code when a fatal error event arrives.
// The code is visible only while the fatal flag is valid, and reads zero
// otherwise.
// Assumes: capture_i is the fatal-error event pulse.
module irq_err_latch #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture_i,
    input  logic [W-1:0] code_i,
    input  logic         valid_i,
    output logic [W-1:0] code_o
);

    logic [W-1:0] code_q;

    // Purpose: hold the code of the most recent fatal error
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (capture_i) begin
            code_q <= code_i;
        end
    end

    // Purpose: hide the code while no fatal error is flagged
    always_comb begin
        code_o = valid_i ? code_q : '0;
    end

endmodule

// File: rtl/dma_irq_status.sv
// Module: dma_irq_status
// The top of the DMA interrupt status aggregator. It holds the sticky event
// flags, the two sticky summaries, the latched bus-error code, the
// pass-through process states and the registered interrupt line.
// Assumes: a write clears every flag or summary whose data bit is 1, and
// all other word positions ignore writes.
module dma_irq_status
    import dma_irq_pkg::*;
#(
    parameter int STATE_W = 3,
    parameter int CODE_W  = 3,
    parameter int WORD_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FLAG_N-1:0]  evt_i,
    input  logic [CODE_W-1:0]  err_code_i,
    input  logic [STATE_W-1:0] tx_state_i,
    input  logic [STATE_W-1:0] rx_state_i,
    input  logic [FLAG_N-1:0]  irq_en_i,
    input  logic               wr_en_i,
    input  logic [WORD_W-1:0]  wr_data_i,
    output logic [WORD_W-1:0]  status_o,
    output logic               sum_norm_o,
    output logic               sum_abn_o,
    output logic               irq_o
);

    localparam int POS_SUM_N = FLAG_N;
    localparam int POS_SUM_A = FLAG_N + 1;
    localparam int POS_ERR   = FLAG_N + 2;
    localparam int POS_TX    = POS_ERR + CODE_W;
    localparam int POS_RX    = POS_TX + STATE_W;
    localparam int USED_W    = POS_RX + STATE_W;

    logic [WORD_W-1:0] wr_clr;
    logic [FLAG_N-1:0] flags;
    logic [FLAG_N-1:0] autoclr;
    logic              sum_n;
    logic              sum_a;
    logic [CODE_W-1:0] err_vis;
    logic              irq_q;
    logic              unused_wr_bits;

    // Purpose: qualify write data into a clear mask
    always_comb begin
        wr_clr = wr_en_i ? wr_data_i : '0;
    end

    // Purpose: receive-done clears the early-receive flag
    always_comb begin
        autoclr              = '0;
        autoclr[FL_RX_EARLY] = evt_i[FL_RX_DONE];
    end

    irq_flag_bank #(.N(FLAG_N)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_i      (evt_i),
        .clr_i     (wr_clr[FLAG_N-1:0]),
        .autoclr_i (autoclr),
        .flags_o   (flags)
    );

    irq_summary #(.N(NORM_N)) u_sum_norm (
        .clk     (clk),
        .rst_n   (rst_n),
        .flags_i (flags[NORM_N-1:0]),
        .en_i    (irq_en_i[NORM_N-1:0]),
        .clr_i   (wr_clr[POS_SUM_N]),
        .sum_o   (sum_n)
    );

    irq_summary #(.N(ABN_N)) u_sum_abn (
        .clk     (clk),
        .rst_n   (rst_n),
        .flags_i (flags[FLAG_N-1:NORM_N]),
        .en_i    (irq_en_i[FLAG_N-1:NORM_N]),
        .clr_i   (wr_clr[POS_SUM_A]),
        .sum_o   (sum_a)
    );

    irq_err_latch #(.W(CODE_W)) u_err (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (evt_i[FL_BUS_FATAL]),
        .code_i    (err_code_i),
        .valid_i   (flags[FL_BUS_FATAL]),
        .code_o    (err_vis)
    );

    // Purpose: register the combined interrupt so it moves only on an edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= sum_n | sum_a;
        end
    end

    // Purpose: fold write bits that address read-only or unused positions
    always_comb begin
        unused_wr_bits = ^wr_clr[WORD_W-1:POS_ERR];
    end

    // Purpose: assemble the status word; unused positions read zero
    always_comb begin
        status_o                       = '0;
        status_o[FLAG_N-1:0]           = flags;
        status_o[POS_SUM_N]            = sum_n;
        status_o[POS_SUM_A]            = sum_a;
        status_o[POS_TX-1:POS_ERR]     = err_vis;
        status_o[POS_RX-1:POS_TX]      = tx_state_i;
        status_o[USED_W-1:POS_RX]      = rx_state_i;
    end

    assign sum_norm_o = sum_n;
    assign sum_abn_o  = sum_a;
    assign irq_o      = irq_q;

endmodule

// File: rtl/dma_irq_status_chk.sv
// Module: dma_irq_status_chk
// Assertion checker for dma_irq_status. It observes only ports and is
// bound to every instance of the top module.
// Assumes: the default word layout derived from the package and parameters.
module dma_irq_status_chk
    import dma_irq_pkg::*;
#(
    parameter int STATE_W = 3,
    parameter int CODE_W  = 3,
    parameter int WORD_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [FLAG_N-1:0]  evt_i,
    input logic [STATE_W-1:0] tx_state_i,
    input logic [STATE_W-1:0] rx_state_i,
    input logic [FLAG_N-1:0]  irq_en_i,
    input logic               wr_en_i,
    input logic [WORD_W-1:0]  wr_data_i,
    input logic [WORD_W-1:0]  status_o,
    input logic               sum_norm_o,
    input logic               sum_abn_o,
    input logic               irq_o
);

    localparam int POS_ERR = FLAG_N + 2;
    localparam int POS_TX  = POS_ERR + CODE_W;
    localparam int POS_RX  = POS_TX + STATE_W;
    localparam int USED_W  = POS_RX + STATE_W;

    logic [FLAG_N-1:0] flg;
    logic [FLAG_N-1:0] wclr;
    logic [FLAG_N-1:0] kill;
    logic [FLAG_N-1:0] ev_keep;
    logic [FLAG_N-1:0] hold;

    // Purpose: derive the per-cycle expectations from the port values
    always_comb begin
        flg               = status_o[FLAG_N-1:0];
        wclr              = wr_en_i ? wr_data_i[FLAG_N-1:0] : '0;
        kill              = '0;
        kill[FL_RX_EARLY] = evt_i[FL_RX_DONE];
        ev_keep           = evt_i & ~kill;
        hold              = flg & ~wclr & ~kill;
    end

    // R3 and R1: a kept event sets its flag, even against a write-1
    a_r3_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_keep) |=> ((status_o[FLAG_N-1:0] & $past(ev_keep)) == $past(ev_keep)));

    // R1: a flag with no clear and no auto-clear stays set
    a_r1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (|hold) |=> (($past(hold) & ~status_o[FLAG_N-1:0]) == '0));

    // R7: receive done removes early receive
    a_r7_early_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i[FL_RX_DONE] |=> !status_o[FL_RX_EARLY]);

    // R4: an enabled normal flag raises the normal summary
    a_r4_norm_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flg[NORM_N-1:0] & irq_en_i[NORM_N-1:0])) |=> sum_norm_o);

    // R5: an enabled abnormal flag raises the abnormal summary
    a_r5_abn_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flg[FLAG_N-1:NORM_N] & irq_en_i[FLAG_N-1:NORM_N])) |=> sum_abn_o);

    // R10: interrupt line trails the summaries by one edge
    a_r10_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == $past(sum_norm_o | sum_abn_o));

    // R8: the error field is hidden while no fatal error is flagged
    a_r8_code_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        !status_o[FL_BUS_FATAL] |-> (status_o[POS_TX-1:POS_ERR] == '0));

    // R9: state fields follow their inputs, upper bits read zero
    a_r9_state_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[POS_RX-1:POS_TX] == tx_state_i) &&
        (status_o[USED_W-1:POS_RX] == rx_state_i) &&
        (status_o[WORD_W-1:USED_W] == '0));

endmodule

bind dma_irq_status dma_irq_status_chk #(
    .STATE_W (STATE_W),
    .CODE_W  (CODE_W),
    .WORD_W  (WORD_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (evt_i),
    .tx_state_i (tx_state_i),
    .rx_state_i (rx_state_i),
    .irq_en_i   (irq_en_i),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .status_o   (status_o),
    .sum_norm_o (sum_norm_o),
    .sum_abn_o  (sum_abn_o),
    .irq_o      (irq_o)
);

// File: tb/sim_dma_irq_status.sv
`timescale 1ns/100ps
// Bench for dma_irq_status: a behavioural reference model compared on
// every clock, plus directed checks per requirement.
module sim_dma_irq_status;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] evt = '0;
    logic [2:0]  code = '0;
    logic [2:0]  txs = '0;
    logic [2:0]  rxs = '0;
    logic [12:0] en = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] status;
    logic        sum_n;
    logic        sum_a;
    logic        irq;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R11";
    bit    done = 1'b0;

    // Reference model state
    logic [12:0] m_f = '0;
    logic        m_sn = 1'b0;
    logic        m_sa = 1'b0;
    logic        m_irq = 1'b0;
    logic [2:0]  m_err = '0;

    dma_irq_status u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt),
        .err_code_i (code),
        .tx_state_i (txs),
        .rx_state_i (rxs),
        .irq_en_i   (en),
        .wr_en_i    (wr_en),
        .wr_data_i  (wr_data),
        .status_o   (status),
        .sum_norm_o (sum_n),
        .sum_abn_o  (sum_a),
        .irq_o      (irq)
    );

    always #2.5 clk = ~clk;

    function automatic logic [31:0] model_word();
        return {8'h00, rxs, txs, (m_f[12] ? m_err : 3'b000), m_sa, m_sn, m_f};
    endfunction

    // Reference model, stepped at each rising edge
    always @(posedge clk) begin
        logic [31:0] clr;
        logic [12:0] nf;
        logic        nsn;
        logic        nsa;
        if (!rst_n) begin
            m_f = '0; m_sn = 0; m_sa = 0; m_irq = 0; m_err = '0;
        end else begin
            clr = wr_en ? wr_data : 32'h0;
            for (int i = 0; i < 13; i++) begin
                if (evt[i]) nf[i] = 1'b1;
                else if (clr[i]) nf[i] = 1'b0;
                else nf[i] = m_f[i];
            end
            if (evt[2]) nf[3] = 1'b0;
            if (evt[12]) m_err = code;
            nsn = ((m_f[3:0] & en[3:0]) != 0) ? 1'b1 : (clr[13] ? 1'b0 : m_sn);
            nsa = ((m_f[12:4] & en[12:4]) != 0) ? 1'b1 : (clr[14] ? 1'b0 : m_sa);
            m_irq = m_sn | m_sa;
            m_sn = nsn;
            m_sa = nsa;
            m_f = nf;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk((status === model_word()) && (sum_n === m_sn) && (sum_a === m_sa)
                && (irq === m_irq), cur_req,
                {status[31:0]}, model_word());
            chk(irq === m_irq, cur_req, {31'b0, irq}, {31'b0, m_irq});
        end
    end

    // One clock: apply inputs, pass the edge, drop pulses
    task automatic cyc(input logic [12:0] e, input logic w, input logic [31:0] d);
        evt = e; wr_en = w; wr_data = d;
        @(posedge clk); #1;
        evt = '0; wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc('0, 1'b0, '0);
    endtask

    task automatic clear_all();
        cyc('0, 1'b1, 32'h0000_7FFF);
        cyc('0, 1'b1, 32'h0000_7FFF);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog
    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        // R11: reset state
        chk(status === 32'h0 && !sum_n && !sum_a && !irq, "R11",
            {status}, 32'h0);
        rst_n = 1'b1;

        // R1 / R2: set, ignore a zero write, then clear
        cur_req = "R1";
        en = '1;
        cyc(13'h0001, 1'b0, '0);
        chk(status[0] === 1'b1, "R1", {31'b0, status[0]}, 32'h1);
        cyc('0, 1'b1, 32'h0);
        chk(status[0] === 1'b1, "R1", {31'b0, status[0]}, 32'h1);
        cur_req = "R2";
        cyc('0, 1'b1, 32'h1);
        chk(status[0] === 1'b0, "R2", {31'b0, status[0]}, 32'h0);

        // R3: event and clear collide on jabber flag (bit 5)
        cur_req = "R3";
        cyc(13'h0020, 1'b1, 32'h20);
        chk(status[5] === 1'b1, "R3", {31'b0, status[5]}, 32'h1);
        clear_all();

        // R4: disabled normal flag does not raise the summary
        cur_req = "R4";
        en = '0;
        clear_all();
        cyc(13'h0002, 1'b0, '0);
        idle(3);
        chk(sum_n === 1'b0, "R4", {31'b0, sum_n}, 32'h0);
        en = 13'h0002;
        idle(1);
        chk(sum_n === 1'b1 && status[13] === 1'b1, "R4", {31'b0, sum_n}, 32'h1);

        // R6: summary refuses a clear while its flag is enabled, then sticks
        cur_req = "R6";
        cyc('0, 1'b1, 32'h2000);
        chk(sum_n === 1'b1, "R6", {31'b0, sum_n}, 32'h1);
        cyc('0, 1'b1, 32'h0002);
        idle(2);
        chk(sum_n === 1'b1 && status[1] === 1'b0, "R6", {31'b0, sum_n}, 32'h1);
        cyc('0, 1'b1, 32'h2000);
        chk(sum_n === 1'b0, "R6", {31'b0, sum_n}, 32'h0);
        idle(2);

        // R5 / R10: abnormal group with a single enabled source
        cur_req = "R5";
        en = 13'h0200;
        cyc(13'h0040, 1'b0, '0);
        idle(3);
        chk(sum_a === 1'b0 && irq === 1'b0, "R5", {31'b0, sum_a}, 32'h0);
        cyc(13'h0200, 1'b0, '0);
        chk(sum_a === 1'b0, "R5", {31'b0, sum_a}, 32'h0);
        cur_req = "R10";
        idle(1);
        chk(sum_a === 1'b1 && irq === 1'b0, "R10", {30'b0, sum_a, irq}, 32'h2);
        idle(1);
        chk(irq === 1'b1, "R10", {31'b0, irq}, 32'h1);
        en = '0;
        clear_all();
        idle(2);
        chk(irq === 1'b0, "R10", {31'b0, irq}, 32'h0);

        // R7: receive done clears early receive, also when simultaneous
        cur_req = "R7";
        cyc(13'h0008, 1'b0, '0);
        chk(status[3] === 1'b1, "R7", {31'b0, status[3]}, 32'h1);
        cyc(13'h0004, 1'b0, '0);
        chk(status[3:2] === 2'b01, "R7", {30'b0, status[3:2]}, 32'h1);
        clear_all();
        cyc(13'h000C, 1'b0, '0);
        chk(status[3:2] === 2'b01, "R7", {30'b0, status[3:2]}, 32'h1);
        clear_all();

        // R8: fatal bus error code latch and visibility
        cur_req = "R8";
        en = '0;
        code = 3'd6;
        cyc(13'h1000, 1'b0, '0);
        code = 3'd2;
        idle(3);
        chk(status[17:15] === 3'd6, "R8", {29'b0, status[17:15]}, 32'h6);
        chk(sum_a === 1'b0 && irq === 1'b0, "R8", {30'b0, sum_a, irq}, 32'h0);
        cyc('0, 1'b1, 32'h0003_8000);
        chk(status[17:15] === 3'd6, "R8", {29'b0, status[17:15]}, 32'h6);
        cyc('0, 1'b1, 32'h1000);
        chk(status[17:15] === 3'd0 && status[12] === 1'b0, "R8",
            {29'b0, status[17:15]}, 32'h0);

        // R9: state fields follow inputs and ignore writes
        cur_req = "R9";
        txs = 3'd5;
        rxs = 3'd2;
        cyc('0, 1'b1, 32'hFFFF_FFFF);
        chk(status[31:18] === {8'h00, 3'd2, 3'd5}, "R9",
            {18'b0, status[31:18]}, {18'b0, 8'h00, 3'd2, 3'd5});

        // Mixed traffic, checked each cycle against the model
        cur_req = "R1";
        for (int k = 0; k < 1500; k++) begin
            if (k % 97 == 0) en = 13'($urandom);
            txs  = 3'($urandom);
            rxs  = 3'($urandom);
            code = 3'($urandom);
            cyc(13'($urandom & $urandom & $urandom), ($urandom % 4) == 0,
                $urandom);
        end
        idle(3);
        finish_run();
    end

endmodule